// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Blanking Controls

This block turns a 4-bit code into the seven active-high segment drives of one display digit. A 1 on a segment output lights that segment. Every one of the sixteen codes has a defined pattern:

- Codes 0 to 9 show decimal digits.
- Codes 10 to 14 show a fixed set of non-hexadecimal glyphs.
- Code 15 shows nothing.

Three active-low controls act on top of the decoded pattern, in a fixed priority:

1. A blanking input turns the whole digit off.
2. A lamp-test input lights every segment.
3. A ripple-blanking input hides a zero.

A ripple-blanking output reports that this digit hid a zero. Wiring that output into the ripple-blanking input of the next lower digit suppresses a run of leading zeros across a multi-digit display. The block is purely combinational and has no clock.

Top module: `seg7_decoder`

## Requirements
- R1: With no control asserted, codes 0 to 9 drive seg_o (bit 6 = a, bit 5 = b, down to bit 0 = g) to 7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h1F, 7'h70, 7'h7F, 7'h73.
- R2: Digit 6 is drawn without its top bar (segment a, bit 6, off) and digit 9 without its bottom bar (segment d, bit 3, off).
- R3: With no control asserted, codes 10, 11, 12, 13 and 14 drive seg_o to 7'h0D, 7'h19, 7'h23, 7'h4B and 7'h0F.
- R4: With no control asserted, code 15 drives seg_o to 7'h00.
- R5: blank_ni low forces seg_o to 7'h00, whatever the code, lamp_test_ni and rbi_ni are.
- R6: lamp_test_ni low with blank_ni high forces seg_o to 7'h7F, whatever the code and rbi_ni are.
- R7: rbi_ni low with code 0, and with blank_ni and lamp_test_ni both high, forces seg_o to 7'h00.
- R8: rbo_no is low exactly when rbi_ni is low, the code is 0 and lamp_test_ni is high. In every other case rbo_no is high. blank_ni does not affect rbo_no.
- R9: rbi_ni low with a nonzero code and no other control asserted has no effect on seg_o.
- R10: The outputs follow a change of any input with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_i | input | 4 | Code to display |
| blank_ni | input | 1 | Blank the digit, active low, highest priority |
| lamp_test_ni | input | 1 | Light all segments, active low |
| rbi_ni | input | 1 | Hide a zero code, active low |
| seg_o | output | 7 | Segment drives, bit 6 = a down to bit 0 = g, 1 = lit |
| rbo_no | output | 1 | Low when this digit hid a zero |

## Verification
The block has no parameters, so the bench builds it with its only configuration. With only seven input bits, the bench covers the whole input space: every code under all eight settings of the three controls. This reaches each priority collision, such as lamp test against ripple blanking on a zero, and blanking against lamp test. A separate unclocked step changes the code between edges to show that the outputs follow at once.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int NCODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  typedef enum logic [1:0] {
    SRC_GLYPH = 2'd0,
    SRC_DARK  = 2'd1,
    SRC_LAMP  = 2'd2
  } src_e;

  localparam seg_t SEG_OFF = '0;
  localparam seg_t SEG_ALL = '1;
endpackage

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
(
  input  code_t code_i,
  output seg_t  glyph_o
);
  // bit 6 = a ... bit 0 = g
  always_comb begin
    unique case (code_i)
      4'd0:    glyph_o = 7'b1111110;
      4'd1:    glyph_o = 7'b0110000;
      4'd2:    glyph_o = 7'b1101101;
      4'd3:    glyph_o = 7'b1111001;
      4'd4:    glyph_o = 7'b0110011;
      4'd5:    glyph_o = 7'b1011011;
      4'd6:    glyph_o = 7'b0011111;
      4'd7:    glyph_o = 7'b1110000;
      4'd8:    glyph_o = 7'b1111111;
      4'd9:    glyph_o = 7'b1110011;
      4'd10:   glyph_o = 7'b0001101;
      4'd11:   glyph_o = 7'b0011001;
      4'd12:   glyph_o = 7'b0100011;
      4'd13:   glyph_o = 7'b1001011;
      4'd14:   glyph_o = 7'b0001111;
      default: glyph_o = SEG_OFF;
    endcase
  end
endmodule

// File: rtl/seg7_zero_ripple.sv
module seg7_zero_ripple
  import seg7_pkg::*;
(
  input  code_t code_i,
  input  logic  rbi_ni,
  input  logic  lamp_test_ni,
  output logic  hide_o,
  output logic  rbo_no
);
  logic is_zero;

  assign is_zero = (code_i == code_t'(0));
  // lamp test wins over zero suppression
  assign hide_o  = ~rbi_ni & is_zero & lamp_test_ni;
  assign rbo_no  = ~hide_o;
endmodule

// File: rtl/seg7_out_sel.sv
module seg7_out_sel
  import seg7_pkg::*;
(
  input  logic blank_ni,
  input  logic lamp_test_ni,
  input  logic hide_i,
  input  seg_t glyph_i,
  output seg_t seg_o
);
  src_e src;

  // priority: blank > lamp test > ripple hide > glyph
  always_comb begin
    if (!blank_ni)          src = SRC_DARK;
    else if (!lamp_test_ni) src = SRC_LAMP;
    else if (hide_i)        src = SRC_DARK;
    else                    src = SRC_GLYPH;
  end

  always_comb begin
    unique case (src)
      SRC_DARK: seg_o = SEG_OFF;
      SRC_LAMP: seg_o = SEG_ALL;
      default:  seg_o = glyph_i;
    endcase
  end
endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
  import seg7_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              blank_ni,
  input  logic              lamp_test_ni,
  input  logic              rbi_ni,
  output logic [SEG_W-1:0]  seg_o,
  output logic              rbo_no
);
  seg_t glyph;
  logic hide;

  seg7_glyph_rom u_rom (
    .code_i  (code_i),
    .glyph_o (glyph)
  );

  seg7_zero_ripple u_zr (
    .code_i       (code_i),
    .rbi_ni       (rbi_ni),
    .lamp_test_ni (lamp_test_ni),
    .hide_o       (hide),
    .rbo_no       (rbo_no)
  );

  seg7_out_sel u_sel (
    .blank_ni     (blank_ni),
    .lamp_test_ni (lamp_test_ni),
    .hide_i       (hide),
    .glyph_i      (glyph),
    .seg_o        (seg_o)
  );
endmodule

// File: rtl/seg7_decoder_chk.sv
module seg7_decoder_chk
  import seg7_pkg::*;
(
  input logic [CODE_W-1:0] code_i,
  input logic              blank_ni,
  input logic              lamp_test_ni,
  input logic              rbi_ni,
  input logic [SEG_W-1:0]  seg_o,
  input logic              rbo_no
);
  logic quiet;
  assign quiet = blank_ni & lamp_test_ni & rbi_ni;

  always_comb begin
    // R5
    blank_off_chk: assert (blank_ni || seg_o == SEG_OFF);
    // R6
    lamp_on_chk: assert (!blank_ni || lamp_test_ni || seg_o == SEG_ALL);
    // R8
    rbo_cause_chk: assert (rbo_no || (!rbi_ni && code_i == '0 && lamp_test_ni));
    // R7
    rbo_dark_chk: assert (rbo_no || !blank_ni || seg_o == SEG_OFF);
    // R4
    code15_dark_chk: assert (!(quiet && code_i == '1) || seg_o == SEG_OFF);
    // R2
    tail_off_chk: assert (!(quiet && code_i == 4'd6) || !seg_o[6]);
    // R2
    tail9_off_chk: assert (!(quiet && code_i == 4'd9) || !seg_o[3]);
  end
endmodule

bind seg7_decoder seg7_decoder_chk u_chk (.*);

// File: tb/sim_seg7_decoder.sv
module sim_seg7_decoder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] code;
  logic       blank_n, lt_n, rbi_n;
  logic [6:0] seg;
  logic       rbo_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  seg7_decoder u0 (
    .code_i       (code),
    .blank_ni     (blank_n),
    .lamp_test_ni (lt_n),
    .rbi_ni       (rbi_n),
    .seg_o        (seg),
    .rbo_no       (rbo_n)
  );

  // lit segments named by letter per code
  string shapes [16] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg", "acdfg",
                         "cdefg", "abc", "abcdefg", "abcfg", "deg", "cdg",
                         "bfg", "adfg", "defg", ""};

  function automatic logic [6:0] shape_mask(int c);
    logic [6:0] m = '0;
    for (int i = 0; i < shapes[c].len(); i++)
      m[6 - (shapes[c][i] - "a")] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [6:0] got, logic [6:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s code=%0d bl=%b lt=%b rbi=%b got=%h exp=%h",
               req, code, blank_n, lt_n, rbi_n, got, exp);
    end
  endtask

  task automatic model_and_check();
    logic [6:0] exp;
    string      tag;
    bit         hid;
    hid = (!rbi_n && code == 0 && lt_n);
    if (!blank_n)                     begin exp = 7'h00; tag = "R5"; end
    else if (!lt_n)                   begin exp = 7'h7F; tag = "R6"; end
    else if (hid)                     begin exp = 7'h00; tag = "R7"; end
    else if (code == 15)              begin exp = 7'h00; tag = "R4"; end
    else if (code >= 10)              begin exp = shape_mask(code); tag = "R3"; end
    else if (code == 6 || code == 9)  begin exp = shape_mask(code); tag = "R2"; end
    else if (!rbi_n)                  begin exp = shape_mask(code); tag = "R9"; end
    else                              begin exp = shape_mask(code); tag = "R1"; end
    check(tag, seg, exp);
    check("R8", {6'b0, rbo_n}, {6'b0, !hid});
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    code = 4'd0; blank_n = 1'b1; lt_n = 1'b1; rbi_n = 1'b1;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", seg, 7'h7E);  // idle state: digit 0 shown
    // spot checks from the stated table values
    code = 4'd6; @(negedge clk); check("R2", seg, 7'h1F);
    code = 4'd9; @(negedge clk); check("R2", seg, 7'h73);
    code = 4'd12; @(negedge clk); check("R3", seg, 7'h23);
    // exhaustive: every code under every control setting
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int c = 0; c < 16; c++) begin
        @(posedge clk);
        code    = 4'(c);
        blank_n = ctl[2];
        lt_n    = ctl[1];
        rbi_n   = ctl[0];
        @(negedge clk);
        model_and_check();
      end
    end
    // R10: outputs settle between edges without a clock
    @(negedge clk);
    blank_n = 1'b1; lt_n = 1'b1; rbi_n = 1'b1;
    code = 4'd3; #1;
    check("R10", seg, 7'h79);
    code = 4'd4; #1;
    check("R10", seg, 7'h33);
    rbi_n = 1'b0; code = 4'd0; #1;
    check("R10", seg, 7'h00);
    check("R10", {6'b0, rbo_n}, 7'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule